// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the scheduling core of a pipeline with four functional units: integer, add/subtract, multiply and divide. Each has its own fixed execution time. Decode is split in two steps. The issue step accepts instructions strictly in program order and holds one back only when its unit is occupied, or when its destination register already has a result pending. The read-operands step then parks each issued instruction in its unit's status entry until every source register is free of outstanding writes. Only then is execution started.

Because the operand wait happens per unit and not at the head of the stream, a younger independent instruction can start and finish before an older one that is still waiting for a slow producer. A register-result table records which unit will write each architectural register next. Write-back goes through a single port. A finished unit may use it only when no waiting instruction still needs to read the old contents of its destination. When it writes back, it clears its table entry and wakes every entry that was waiting on it.

Register values, fetch, branches and arithmetic are outside this block. The per-unit start and done pulses and the write-back port drive the surrounding datapath.

Top module: `scoreboard_ctrl`

## Requirements
- R1: Instructions are accepted in program order. `instr_ready_o` is high exactly when the unit named by `instr_class_i` is idle and the destination register has no pending writer. An instruction is accepted in any cycle where `instr_valid_i` and `instr_ready_o` are both high.
- R2: An instruction whose unit is busy is not accepted. It is accepted the cycle after that unit's write-back.
- R3: An instruction whose destination register has a pending writer is not accepted. It is accepted the cycle after that writer's write-back.
- R4: An issued instruction asserts its unit's bit of `fu_start_o` for one cycle. This happens in the first cycle, at the earliest the cycle after acceptance, in which neither source register waits on an unwritten result. When a source's producer writes back, the start follows one cycle later.
- R5: A younger instruction with no dependence on a stalled older one starts and writes back before the older one starts.
- R6: A unit's bit of `fu_done_o` pulses exactly LAT cycles after its start pulse. LAT is 1, 2, 6 and 20 for the integer, add, multiply and divide units.
- R7: A finished unit does not write back while any issued instruction that has not yet started still needs to read its destination register. It writes back the cycle after the last such reader starts, at the earliest.
- R8: At most one write-back happens per cycle, at the earliest the cycle after the done pulse. Among eligible units the lowest unit number wins. `wb_unit_o` and `wb_reg_o` give the unit and the destination register.
- R9: A write-back frees the unit in the next cycle and clears the destination's pending-writer mark. It also releases any waiting source that named this unit as its producer, including one issued in the same cycle as the write-back.
- R10: After reset `instr_ready_o` is high for any instruction. `fu_start_o`, `fu_done_o` and `wb_valid_o` are low.
- R11: The class code selects the unit: 0 integer, 1 add/subtract, 2 multiply, 3 divide. The bit index of `fu_start_o`, `fu_done_o` and the value of `wb_unit_o` use the same numbering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | An instruction is presented |
| instr_class_i | input | 2 | Unit class of the instruction (R11 encoding) |
| instr_dst_i | input | REG_W (3) | Destination register number |
| instr_src1_i | input | REG_W (3) | First source register number |
| instr_src2_i | input | REG_W (3) | Second source register number |
| instr_ready_o | output | 1 | Instruction can be accepted this cycle |
| fu_start_o | output | 4 | Per-unit pulse: operands read, execution begins |
| fu_done_o | output | 4 | Per-unit pulse: execution finished |
| wb_valid_o | output | 1 | A result is written back this cycle |
| wb_unit_o | output | 2 | Unit writing back |
| wb_reg_o | output | REG_W (3) | Register written back |

## Verification
On every cycle the assertions check several local rules. No issue lands in an occupied unit. No pending writer is overwritten in the result table. A write-back always clears a mark held by the writing unit. A grant only goes to a finished unit. An executing unit holds until its counter runs out. A granted write-back never targets a register that a waiting entry still reads. A written-back unit is idle the next cycle. The ordering effects depend on whole instruction sequences, so only the bench scenarios can show them: an independent instruction overtaking a stalled one, the exact stall lengths caused by structural, WAW and WAR hazards, and priority between simultaneous finishers. The bench compares every output each cycle against a behavioural model.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU = 4;
  localparam int FU_W   = 2;

  typedef enum logic [FU_W-1:0] {
    FU_INT = 2'd0,
    FU_ADD = 2'd1,
    FU_MUL = 2'd2,
    FU_DIV = 2'd3
  } fu_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_EXEC,
    PH_WB
  } phase_e;
endpackage

// File: rtl/sb_regstat.sv
module sb_regstat #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 3,
  parameter int FU_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] look_dst_i,
  input  logic [REG_W-1:0] look_s1_i,
  input  logic [REG_W-1:0] look_s2_i,
  output logic             dst_pend_o,
  output logic             s1_pend_o,
  output logic [FU_W-1:0]  s1_fu_o,
  output logic             s2_pend_o,
  output logic [FU_W-1:0]  s2_fu_o,
  input  logic             set_i,
  input  logic [REG_W-1:0] set_reg_i,
  input  logic [FU_W-1:0]  set_fu_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] clr_reg_i,
  input  logic [FU_W-1:0]  clr_fu_i
);
  logic [NUM_REGS-1:0] pend_q;
  logic [FU_W-1:0]     fu_q [NUM_REGS];

  assign dst_pend_o = pend_q[look_dst_i];
  assign s1_pend_o  = pend_q[look_s1_i];
  assign s1_fu_o    = fu_q[look_s1_i];
  assign s2_pend_o  = pend_q[look_s2_i];
  assign s2_fu_o    = fu_q[look_s2_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      for (int r = 0; r < NUM_REGS; r++) fu_q[r] <= '0;
    end else begin
      if (clr_i) pend_q[clr_reg_i] <= 1'b0;
      if (set_i) begin
        pend_q[set_reg_i] <= 1'b1;
        fu_q[set_reg_i]   <= set_fu_i;
      end
    end
  end

  // issue must never replace a pending writer
  a_r3_no_waw_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !pend_q[set_reg_i]);

  // write-back clears a mark owned by the writer
  a_r9_clear_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (pend_q[clr_reg_i] && fu_q[clr_reg_i] == clr_fu_i));
endmodule

// File: rtl/sb_issue.sv
module sb_issue #(
  parameter int NUM_FU = 4,
  parameter int FU_W   = 2
) (
  input  logic              valid_i,
  input  logic [FU_W-1:0]   class_i,
  input  logic [NUM_FU-1:0] busy_i,
  input  logic              dst_pend_i,
  input  logic              s1_pend_i,
  input  logic [FU_W-1:0]   s1_fu_i,
  input  logic              s2_pend_i,
  input  logic [FU_W-1:0]   s2_fu_i,
  input  logic              wb_valid_i,
  input  logic [FU_W-1:0]   wb_unit_i,
  output logic              ready_o,
  output logic [NUM_FU-1:0] issue_sel_o,
  output logic              q1_vld_o,
  output logic              q2_vld_o
);
  logic go;

  assign ready_o     = !busy_i[class_i] && !dst_pend_i;
  assign go          = valid_i && ready_o;
  assign issue_sel_o = go ? (NUM_FU'(1) << class_i) : '0;

  // a producer retiring this cycle no longer counts as pending
  assign q1_vld_o = s1_pend_i && !(wb_valid_i && wb_unit_i == s1_fu_i);
  assign q2_vld_o = s2_pend_i && !(wb_valid_i && wb_unit_i == s2_fu_i);
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
  import sb_pkg::*;
#(
  parameter int LAT   = 1,
  parameter int REG_W = 3,
  parameter int FU_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src1_i,
  input  logic [REG_W-1:0] src2_i,
  input  logic             q1_vld_i,
  input  logic [FU_W-1:0]  q1_i,
  input  logic             q2_vld_i,
  input  logic [FU_W-1:0]  q2_i,
  input  logic             wb_valid_i,
  input  logic [FU_W-1:0]  wb_unit_i,
  input  logic             grant_i,
  output logic             busy_o,
  output logic             start_o,
  output logic             done_o,
  output logic             wb_req_o,
  output logic [REG_W-1:0] dst_o,
  output logic [REG_W-1:0] src1_o,
  output logic [REG_W-1:0] src2_o,
  output logic             rd1_pend_o,
  output logic             rd2_pend_o
);
  localparam int CNT_W = $clog2(LAT + 1);

  phase_e           ph_q;
  logic [REG_W-1:0] dst_q, s1_q, s2_q;
  logic [FU_W-1:0]  q1_q, q2_q;
  logic             r1_q, r2_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o     = ph_q != PH_IDLE;
  assign start_o    = ph_q == PH_WAIT && r1_q && r2_q;
  assign done_o     = ph_q == PH_EXEC && cnt_q == '0;
  assign wb_req_o   = ph_q == PH_WB;
  assign dst_o      = dst_q;
  assign src1_o     = s1_q;
  assign src2_o     = s2_q;
  assign rd1_pend_o = ph_q == PH_WAIT && r1_q;
  assign rd2_pend_o = ph_q == PH_WAIT && r2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      dst_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      q1_q  <= '0;
      q2_q  <= '0;
      r1_q  <= 1'b0;
      r2_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (issue_i) begin
          ph_q  <= PH_WAIT;
          dst_q <= dst_i;
          s1_q  <= src1_i;
          s2_q  <= src2_i;
          q1_q  <= q1_i;
          q2_q  <= q2_i;
          r1_q  <= !q1_vld_i;
          r2_q  <= !q2_vld_i;
        end
        PH_WAIT: begin
          if (start_o) begin
            ph_q  <= PH_EXEC;
            cnt_q <= CNT_W'(LAT - 1);
            r1_q  <= 1'b0;  // operands read: old values no longer needed
            r2_q  <= 1'b0;
          end else begin
            if (wb_valid_i && !r1_q && q1_q == wb_unit_i) r1_q <= 1'b1;
            if (wb_valid_i && !r2_q && q2_q == wb_unit_i) r2_q <= 1'b1;
          end
        end
        PH_EXEC: begin
          if (cnt_q == '0) ph_q <= PH_WB;
          else             cnt_q <= cnt_q - 1'b1;
        end
        PH_WB: if (grant_i) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  a_r2_issue_into_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> ph_q == PH_IDLE);

  a_r6_exec_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_EXEC && cnt_q != '0) |=> ph_q == PH_EXEC);

  a_r8_grant_finished: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> ph_q == PH_WB);
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int NUM_FU = 4,
  parameter int REG_W  = 3,
  parameter int FU_W   = 2
) (
  input  logic [NUM_FU-1:0] req_i,
  input  logic [REG_W-1:0]  dst_i  [NUM_FU],
  input  logic [REG_W-1:0]  src1_i [NUM_FU],
  input  logic [REG_W-1:0]  src2_i [NUM_FU],
  input  logic [NUM_FU-1:0] rd1_pend_i,
  input  logic [NUM_FU-1:0] rd2_pend_i,
  output logic [NUM_FU-1:0] grant_o,
  output logic              wb_valid_o,
  output logic [FU_W-1:0]   wb_unit_o,
  output logic [REG_W-1:0]  wb_reg_o
);
  logic [NUM_FU-1:0] war_clear;
  logic [NUM_FU-1:0] elig;

  // WAR: nobody still waiting to read the old destination value
  for (genvar u = 0; u < NUM_FU; u++) begin : g_war
    always_comb begin
      war_clear[u] = 1'b1;
      for (int g = 0; g < NUM_FU; g++) begin
        if ((rd1_pend_i[g] && src1_i[g] == dst_i[u]) ||
            (rd2_pend_i[g] && src2_i[g] == dst_i[u]))
          war_clear[u] = 1'b0;
      end
    end
  end

  assign elig = req_i & war_clear;

  always_comb begin
    grant_o    = '0;
    wb_valid_o = 1'b0;
    wb_unit_o  = '0;
    wb_reg_o   = '0;
    for (int u = NUM_FU - 1; u >= 0; u--) begin
      if (elig[u]) begin
        grant_o    = NUM_FU'(1) << u;
        wb_valid_o = 1'b1;
        wb_unit_o  = FU_W'(u);
        wb_reg_o   = dst_i[u];
      end
    end
  end
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int LAT_INT  = 1,
  parameter int LAT_ADD  = 2,
  parameter int LAT_MUL  = 6,
  parameter int LAT_DIV  = 20,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [FU_W-1:0]   instr_class_i,
  input  logic [REG_W-1:0]  instr_dst_i,
  input  logic [REG_W-1:0]  instr_src1_i,
  input  logic [REG_W-1:0]  instr_src2_i,
  output logic              instr_ready_o,
  output logic [NUM_FU-1:0] fu_start_o,
  output logic [NUM_FU-1:0] fu_done_o,
  output logic              wb_valid_o,
  output logic [FU_W-1:0]   wb_unit_o,
  output logic [REG_W-1:0]  wb_reg_o
);
  logic [NUM_FU-1:0] busy, wb_req, grant, rd1_pend, rd2_pend, issue_sel;
  logic [REG_W-1:0]  dst_q [NUM_FU];
  logic [REG_W-1:0]  s1_q  [NUM_FU];
  logic [REG_W-1:0]  s2_q  [NUM_FU];
  logic              dst_pend, s1_pend, s2_pend, q1_vld, q2_vld;
  logic [FU_W-1:0]   s1_fu, s2_fu;

  sb_regstat #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .FU_W(FU_W)) u_regstat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .look_dst_i (instr_dst_i),
    .look_s1_i  (instr_src1_i),
    .look_s2_i  (instr_src2_i),
    .dst_pend_o (dst_pend),
    .s1_pend_o  (s1_pend),
    .s1_fu_o    (s1_fu),
    .s2_pend_o  (s2_pend),
    .s2_fu_o    (s2_fu),
    .set_i      (|issue_sel),
    .set_reg_i  (instr_dst_i),
    .set_fu_i   (instr_class_i),
    .clr_i      (wb_valid_o),
    .clr_reg_i  (wb_reg_o),
    .clr_fu_i   (wb_unit_o)
  );

  sb_issue #(.NUM_FU(NUM_FU), .FU_W(FU_W)) u_issue (
    .valid_i     (instr_valid_i),
    .class_i     (instr_class_i),
    .busy_i      (busy),
    .dst_pend_i  (dst_pend),
    .s1_pend_i   (s1_pend),
    .s1_fu_i     (s1_fu),
    .s2_pend_i   (s2_pend),
    .s2_fu_i     (s2_fu),
    .wb_valid_i  (wb_valid_o),
    .wb_unit_i   (wb_unit_o),
    .ready_o     (instr_ready_o),
    .issue_sel_o (issue_sel),
    .q1_vld_o    (q1_vld),
    .q2_vld_o    (q2_vld)
  );

  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    localparam int LAT_SEL = (g == int'(FU_INT)) ? LAT_INT :
                             (g == int'(FU_ADD)) ? LAT_ADD :
                             (g == int'(FU_MUL)) ? LAT_MUL : LAT_DIV;
    sb_fu_slot #(.LAT(LAT_SEL), .REG_W(REG_W), .FU_W(FU_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .issue_i    (issue_sel[g]),
      .dst_i      (instr_dst_i),
      .src1_i     (instr_src1_i),
      .src2_i     (instr_src2_i),
      .q1_vld_i   (q1_vld),
      .q1_i       (s1_fu),
      .q2_vld_i   (q2_vld),
      .q2_i       (s2_fu),
      .wb_valid_i (wb_valid_o),
      .wb_unit_i  (wb_unit_o),
      .grant_i    (grant[g]),
      .busy_o     (busy[g]),
      .start_o    (fu_start_o[g]),
      .done_o     (fu_done_o[g]),
      .wb_req_o   (wb_req[g]),
      .dst_o      (dst_q[g]),
      .src1_o     (s1_q[g]),
      .src2_o     (s2_q[g]),
      .rd1_pend_o (rd1_pend[g]),
      .rd2_pend_o (rd2_pend[g])
    );

    a_r7_no_war_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_valid_o |-> !((rd1_pend[g] && s1_q[g] == wb_reg_o) ||
                       (rd2_pend[g] && s2_q[g] == wb_reg_o)));
  end

  sb_wb_arb #(.NUM_FU(NUM_FU), .REG_W(REG_W), .FU_W(FU_W)) u_arb (
    .req_i      (wb_req),
    .dst_i      (dst_q),
    .src1_i     (s1_q),
    .src2_i     (s2_q),
    .rd1_pend_i (rd1_pend),
    .rd2_pend_i (rd2_pend),
    .grant_o    (grant),
    .wb_valid_o (wb_valid_o),
    .wb_unit_o  (wb_unit_o),
    .wb_reg_o   (wb_reg_o)
  );

  a_r9_unit_freed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !busy[$past(wb_unit_o)]);
endmodule

// File: tb/tb_scoreboard_ctrl.sv
module tb_scoreboard_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_class = '0;
  logic [2:0] in_dst = '0, in_s1 = '0, in_s2 = '0;
  logic       ready;
  logic [3:0] start, done;
  logic       wbv;
  logic [1:0] wbu;
  logic [2:0] wbr;

  always #2 clk = ~clk;  // 250 MHz

  scoreboard_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(in_valid), .instr_class_i(in_class),
    .instr_dst_i(in_dst), .instr_src1_i(in_s1), .instr_src2_i(in_s2),
    .instr_ready_o(ready), .fu_start_o(start), .fu_done_o(done),
    .wb_valid_o(wbv), .wb_unit_o(wbu), .wb_reg_o(wbr)
  );

  int n_tests = 0, n_fail = 0;
  int gcyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    gcyc++;
    if (gcyc > 100000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", gcyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // behavioural reference model
  int lat [4] = '{1, 2, 6, 20};
  int m_ph [4], m_dst [4], m_s1 [4], m_s2 [4], m_q1 [4], m_q2 [4];
  int m_r1 [4], m_r2 [4], m_cnt [4];
  int m_rs [8];
  bit m_ready, m_wbv;
  int m_wbu, m_wbr;
  bit m_start [4], m_done [4];

  task automatic model_reset();
    for (int u = 0; u < 4; u++) begin
      m_ph[u] = 0; m_r1[u] = 0; m_r2[u] = 0; m_cnt[u] = 0;
      m_q1[u] = -1; m_q2[u] = -1;
    end
    for (int r = 0; r < 8; r++) m_rs[r] = -1;
  endtask

  task automatic model_comb(input int cls, input int d);
    m_ready = (m_ph[cls] == 0) && (m_rs[d] < 0);
    for (int u = 0; u < 4; u++) begin
      m_start[u] = (m_ph[u] == 1) && m_r1[u] != 0 && m_r2[u] != 0;
      m_done[u]  = (m_ph[u] == 2) && m_cnt[u] == 0;
    end
    m_wbv = 0; m_wbu = 0; m_wbr = 0;
    for (int u = 0; u < 4; u++) begin
      bit clear = 1;
      if (m_ph[u] != 3 || m_wbv) continue;
      for (int g = 0; g < 4; g++)
        if (m_ph[g] == 1 && ((m_r1[g] != 0 && m_s1[g] == m_dst[u]) ||
                             (m_r2[g] != 0 && m_s2[g] == m_dst[u])))
          clear = 0;
      if (clear) begin m_wbv = 1; m_wbu = u; m_wbr = m_dst[u]; end
    end
  endtask

  task automatic model_seq(input bit iss, input int cls, input int d, input int a, input int b);
    int qa, qb;
    qa = m_rs[a]; qb = m_rs[b];
    if (m_wbv && qa == m_wbu) qa = -1;
    if (m_wbv && qb == m_wbu) qb = -1;
    for (int u = 0; u < 4; u++) begin
      case (m_ph[u])
        1: if (m_start[u]) begin
             m_ph[u] = 2; m_cnt[u] = lat[u] - 1; m_r1[u] = 0; m_r2[u] = 0;
           end else if (m_wbv) begin
             if (m_r1[u] == 0 && m_q1[u] == m_wbu) m_r1[u] = 1;
             if (m_r2[u] == 0 && m_q2[u] == m_wbu) m_r2[u] = 1;
           end
        2: if (m_cnt[u] == 0) m_ph[u] = 3; else m_cnt[u]--;
        3: if (m_wbv && m_wbu == u) m_ph[u] = 0;
        default: ;
      endcase
    end
    if (m_wbv) m_rs[m_wbr] = -1;
    if (iss) begin
      m_ph[cls] = 1; m_dst[cls] = d; m_s1[cls] = a; m_s2[cls] = b;
      m_q1[cls] = qa; m_q2[cls] = qb;
      m_r1[cls] = (qa < 0); m_r2[cls] = (qb < 0);
      m_rs[d] = cls;
    end
  endtask

  // program storage and per-run event records
  int p_cls [16], p_d [16], p_a [16], p_b [16];
  int acc [16];
  int st [4], dn [4], wbc [4];

  task automatic set_ins(input int i, input int c, input int d, input int a, input int b);
    p_cls[i] = c; p_d[i] = d; p_a[i] = a; p_b[i] = b;
  endtask

  task automatic run_prog(input int n);
    int idx = 0, cyc = 0;
    bit idle;
    for (int u = 0; u < 4; u++) begin st[u] = -1; dn[u] = -1; wbc[u] = -1; end
    for (int i = 0; i < 16; i++) acc[i] = -1;
    forever begin
      bit iss;
      @(negedge clk);
      if (idx < n) begin
        in_valid = 1; in_class = p_cls[idx][1:0]; in_dst = p_d[idx][2:0];
        in_s1 = p_a[idx][2:0]; in_s2 = p_b[idx][2:0];
      end else begin
        in_valid = 0; in_class = '0; in_dst = '0; in_s1 = '0; in_s2 = '0;
      end
      #1;
      model_comb(int'(in_class), int'(in_dst));
      chk(ready == m_ready, "R1 ready", ready, m_ready);
      for (int u = 0; u < 4; u++) begin
        chk(start[u] == m_start[u], "R4 start", start[u], m_start[u]);
        chk(done[u] == m_done[u], "R6 done", done[u], m_done[u]);
        if (start[u] && st[u] < 0) st[u] = cyc;
        if (done[u] && dn[u] < 0) dn[u] = cyc;
      end
      chk(wbv == m_wbv, "R8 wb_valid", wbv, m_wbv);
      if (m_wbv) begin
        chk(wbu == m_wbu[1:0], "R8 wb_unit", wbu, m_wbu);
        chk(wbr == m_wbr[2:0], "R8 wb_reg", wbr, m_wbr);
      end
      if (wbv && wbc[wbu] < 0) wbc[wbu] = cyc;
      iss = in_valid && m_ready;
      if (iss) acc[idx] = cyc;
      @(posedge clk);
      model_seq(iss, int'(in_class), int'(in_dst), int'(in_s1), int'(in_s2));
      if (iss) idx++;
      cyc++;
      idle = 1;
      for (int u = 0; u < 4; u++) if (m_ph[u] != 0) idle = 0;
      if (idx == n && idle) break;
      if (cyc > 2000) begin
        chk(0, "R1 program stuck", cyc, 2000);
        break;
      end
    end
  endtask

  initial begin
    int seed;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(ready == 1'b1, "R10 ready after reset", ready, 1);
    chk(start == 4'b0, "R10 no start", start, 0);
    chk(done == 4'b0, "R10 no done", done, 0);
    chk(wbv == 1'b0, "R10 no write-back", wbv, 0);

    // R5/R4: div r0; add r5<-r0; independent int r6
    set_ins(0, 3, 0, 2, 4);
    set_ins(1, 1, 5, 0, 3);
    set_ins(2, 0, 6, 3, 7);
    run_prog(3);
    chk(wbc[0] < st[1], "R5 younger wb before older start", wbc[0], st[1]);
    chk(st[0] < st[1], "R5 younger starts first", st[0], st[1]);
    chk(st[1] == wbc[3] + 1, "R4 start after producer wb", st[1], wbc[3] + 1);
    chk(dn[3] == st[3] + 20, "R6 divide latency", dn[3], st[3] + 20);
    chk(st[0] == acc[2] + 1, "R4 ready operands start next cycle", st[0], acc[2] + 1);

    // R7 WAR: int writes r4 that the waiting mul still reads
    set_ins(0, 3, 0, 1, 2);
    set_ins(1, 2, 3, 0, 4);
    set_ins(2, 0, 4, 5, 6);
    run_prog(3);
    chk(wbc[0] == st[2] + 1, "R7 write held until reader starts", wbc[0], st[2] + 1);
    chk(dn[2] == st[2] + 6, "R6 multiply latency", dn[2], st[2] + 6);

    // R3 WAW
    set_ins(0, 2, 1, 2, 3);
    set_ins(1, 1, 1, 4, 5);
    run_prog(2);
    chk(acc[1] == wbc[2] + 1, "R3 waw issue after writer wb", acc[1], wbc[2] + 1);

    // R2/R9 structural
    set_ins(0, 2, 2, 3, 4);
    set_ins(1, 2, 5, 6, 7);
    run_prog(2);
    chk(acc[1] == wbc[2] + 1, "R2 busy unit blocks until wb", acc[1], wbc[2] + 1);

    // R8 priority: add and int finish together
    set_ins(0, 1, 1, 2, 3);
    set_ins(1, 0, 4, 5, 6);
    run_prog(2);
    chk(dn[0] == dn[1], "R8 both done same cycle", dn[0], dn[1]);
    chk(wbc[1] == wbc[0] + 1, "R8 lower unit writes first", wbc[1], wbc[0] + 1);
    chk(dn[1] == st[1] + 2, "R6 add latency", dn[1], st[1] + 2);
    chk(wbc[0] == dn[0] + 1, "R8 wb cycle after done", wbc[0], dn[0] + 1);

    // R9 same-cycle wake: reader issued while producer writes back
    set_ins(0, 0, 3, 1, 2);
    set_ins(1, 1, 7, 1, 2);
    set_ins(2, 2, 6, 3, 3);
    run_prog(3);
    chk(st[2] >= 0, "R9 dependent released", st[2], 0);

    // R11 encoding
    set_ins(0, 2, 7, 7, 7);
    run_prog(1);
    chk(st[2] >= 0 && st[0] < 0 && st[1] < 0 && st[3] < 0, "R11 class 2 on multiply unit",
        st[2], 1);
    chk(wbc[2] >= 0, "R11 wb_unit 2", wbc[2], 1);

    // mixed pseudo-random stream against the model (R1 order)
    seed = 7;
    for (int i = 0; i < 14; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      set_ins(i, (seed >> 4) & 3, (seed >> 8) & 7, (seed >> 12) & 7, (seed >> 16) & 7);
    end
    run_prog(14);
    for (int i = 1; i < 14; i++)
      chk(acc[i] > acc[i-1], "R1 in-order acceptance", acc[i], acc[i-1] + 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule